// File: doc/BRIEF.md
# Lockable Watchdog Timer with Tap Select

This block is a retriggerable watchdog. It stays idle after reset until software sends its first kick strobe. From then on, every kick restarts the count from zero. If the count reaches the terminal value chosen by the configuration, the block emits a one-cycle reset pulse and sets a sticky flag. The flag records that the most recent reset came from the watchdog.

The count runs either on every system clock or on a slow tick that stands in for an on-chip RC oscillator. A two-bit tap field scales the timeout by 1, 2, 4 or 16 times a base count. Two further bits decide whether counting continues while the core is halted and while it is stopped.

The eight-bit configuration register is write-only. It accepts writes only during a short window after power-on reset, after a watchdog reset, or after a stop-mode wake-up. Outside that window it is locked.

Top module: `wdog_lockable`

## Requirements
- R1: After power-on reset the timer is disabled: `wdt_rst_o` and `wdt_cause_o` are 0, and no reset pulse appears for as long as no kick arrives.
- R2: The first kick enables the timer. Any later kick restarts the count from zero, so the full timeout runs again from that kick.
- R3: With register bit 4 = 1 (system clock source), tap codes 00, 01, 10 and 11 in bits [1:0] give timeouts of 1, 2, 4 and 16 times `XTAL_BASE` clocks (256, 512, 1024 and 4096 by default). The timeout is counted in clock edges after the kick edge, up to the edge that raises the pulse.
- R4: With bit 4 = 0 (RC tick source), the same tap codes give timeouts of 1, 2, 4 and 16 times `RC_BASE` edges on which `rc_tick_i` is high.
- R5: The register resets to 0x0D: RC source, counting in stop, counting in halt, tap 01.
- R6: Bit 2 = 0 freezes the count while `halt_i` is high. Bit 2 = 1 lets the count continue while `halt_i` is high.
- R7: Bit 3 = 0 freezes the count while `stop_i` is high. Bit 3 = 1 lets the count continue while `stop_i` is high.
- R8: A register write is accepted only on the clock edges numbered 0 to `WIN_CYCLES`-1 (0 to 127), counted from the first edge after power-on reset is released, after a watchdog-reset pulse, or after a `stop_wake_i` edge. A write on edge 128 or later is ignored until the next such event.
- R9: Only writes with `cfg_addr_i` equal to `CFG_ADDR` (0x0F) reach the register. Writes to any other address are ignored.
- R10: Bits [7:5] of a write are reserved and are stored as 0. They have no effect on the timer.
- R11: The reset output is a single-cycle pulse. On the clock edge after the pulse, the register returns to 0x0D, the timer is disabled and the write window reopens.
- R12: `wdt_cause_o` goes to 1 on the clock edge after a watchdog pulse. It stays at 1 through later stop wake-ups and pulses, and only power-on reset clears it.
- R13: A kick on the same edge at which the terminal count would be reached wins: no pulse appears, and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System (crystal) clock |
| por_ni | input | 1 | Asynchronous active-low power-on reset |
| rc_tick_i | input | 1 | One-clock enable marking an RC-oscillator period |
| kick_i | input | 1 | Enable / restart strobe |
| halt_i | input | 1 | Core is in halt mode |
| stop_i | input | 1 | Core is in stop mode |
| stop_wake_i | input | 1 | Stop-mode recovery event; reopens the write window |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | ADDR_W | Register write address |
| cfg_wdata_i | input | 8 | Register write data |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |
| wdt_cause_o | output | 1 | Sticky flag: last reset came from the watchdog |

## Verification
The assertions check the following on every cycle:
- the pulse lasts a single cycle;
- a kick always suppresses the next pulse;
- a disabled timer never fires;
- a frozen count holds its value;
- a closed window holds both the lock and the register contents;
- the cause flag sets after a pulse and then stays set.

Only the bench's scenarios can show the exact timeout lengths for each source and tap, and the exact edge at which the window closes. The same holds for the restore of the register defaults after a watchdog pulse, and for the effect of the register bits, since the register cannot be read back.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // Register layout, MSB first: bit4 source, bit3 stop-run, bit2 halt-run, bits1:0 tap
   typedef struct packed {
      logic       xtal_sel;
      logic       stop_run;
      logic       halt_run;
      logic [1:0] tap;
   } wdog_cfg_t;

   localparam wdog_cfg_t CFG_DEFAULT = '{xtal_sel: 1'b0, stop_run: 1'b1,
                                         halt_run: 1'b1, tap: 2'b01};

   localparam int unsigned CFG_BITS = $bits(wdog_cfg_t);

endpackage

// File: rtl/wdog_win.sv
module wdog_win #(
   parameter int unsigned WIN_CYCLES = 128
) (
   input  logic clk_i,
   input  logic por_ni,
   input  logic reopen_i,
   output logic open_o
);
   localparam int unsigned WW = $clog2(WIN_CYCLES + 1);
   localparam logic [WW-1:0] WLIM = WW'(WIN_CYCLES);

   logic [WW-1:0] age_q;

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)             age_q <= '0;
      else if (reopen_i)       age_q <= '0;
      else if (age_q < WLIM)   age_q <= age_q + WW'(1);
   end

   assign open_o = (age_q < WLIM);

   // once closed, only a reopen event can open it again
   p_lock_holds_r8: assert property (@(posedge clk_i) disable iff (!por_ni)
      (!open_o && !reopen_i) |=> !open_o);

endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
   import wdog_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 'h0F
) (
   input  logic              clk_i,
   input  logic              por_ni,
   input  logic              win_open_i,
   input  logic              restore_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output wdog_cfg_t         cfg_o
);
   logic hit;
   assign hit = we_i && (addr_i == CFG_ADDR) && win_open_i;

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)        cfg_o <= CFG_DEFAULT;
      else if (restore_i) cfg_o <= CFG_DEFAULT;
      else if (hit)       cfg_o <= wdog_cfg_t'(wdata_i[CFG_BITS-1:0]);
   end

   p_cfg_locked_r8: assert property (@(posedge clk_i) disable iff (!por_ni)
      (!win_open_i && !restore_i) |=> $stable(cfg_o));
   p_addr_filter_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
      (!restore_i && !(we_i && addr_i == CFG_ADDR)) |=> $stable(cfg_o));
   p_restore_r11: assert property (@(posedge clk_i) disable iff (!por_ni)
      restore_i |=> (cfg_o == CFG_DEFAULT));

endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt
   import wdog_pkg::*;
#(
   parameter int unsigned XTAL_BASE = 256,
   parameter int unsigned RC_BASE   = 5
) (
   input  logic      clk_i,
   input  logic      por_ni,
   input  wdog_cfg_t cfg_i,
   input  logic      rc_tick_i,
   input  logic      kick_i,
   input  logic      halt_i,
   input  logic      stop_i,
   output logic      fire_o
);
   localparam int unsigned MAXB = (XTAL_BASE > RC_BASE) ? XTAL_BASE : RC_BASE;
   localparam int unsigned CW   = $clog2(MAXB * 16 + 1);

   logic          en_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] base, term;
   logic          step, frozen, advance;

   // the count source is picked at run time; the base for each is fixed at elaboration
   assign base = cfg_i.xtal_sel ? CW'(XTAL_BASE) : CW'(RC_BASE);

   always_comb begin
      unique case (cfg_i.tap)
         2'b00:   term = base;
         2'b01:   term = base << 1;
         2'b10:   term = base << 2;
         default: term = base << 4;
      endcase
   end

   assign step    = cfg_i.xtal_sel ? 1'b1 : rc_tick_i;
   assign frozen  = (halt_i && !cfg_i.halt_run) || (stop_i && !cfg_i.stop_run);
   assign advance = en_q && step && !frozen;

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) begin
         en_q   <= 1'b0;
         cnt_q  <= '0;
         fire_o <= 1'b0;
      end else begin
         fire_o <= 1'b0;
         if (kick_i) begin
            en_q  <= 1'b1;
            cnt_q <= '0;
         end else if (advance) begin
            if (cnt_q >= term - CW'(1)) begin
               fire_o <= 1'b1;
               en_q   <= 1'b0;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end
      end
   end

   p_pulse_one_r11: assert property (@(posedge clk_i) disable iff (!por_ni)
      fire_o |=> !fire_o);
   p_kick_wins_r13: assert property (@(posedge clk_i) disable iff (!por_ni)
      kick_i |=> !fire_o);
   p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!por_ni)
      (!en_q && !kick_i) |=> !fire_o);
   p_halt_freeze_r6: assert property (@(posedge clk_i) disable iff (!por_ni)
      (halt_i && !cfg_i.halt_run && !kick_i) |=> $stable(cnt_q));
   p_stop_freeze_r7: assert property (@(posedge clk_i) disable iff (!por_ni)
      (stop_i && !cfg_i.stop_run && !kick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
   import wdog_pkg::*;
#(
   parameter int unsigned       WIN_CYCLES = 128,
   parameter int unsigned       ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR   = 'h0F,
   parameter int unsigned       XTAL_BASE  = 256,
   parameter int unsigned       RC_BASE    = 5
) (
   input  logic              clk_i,
   input  logic              por_ni,
   input  logic              rc_tick_i,
   input  logic              kick_i,
   input  logic              halt_i,
   input  logic              stop_i,
   input  logic              stop_wake_i,
   input  logic              cfg_we_i,
   input  logic [ADDR_W-1:0] cfg_addr_i,
   input  logic [7:0]        cfg_wdata_i,
   output logic              wdt_rst_o,
   output logic              wdt_cause_o
);
   if (WIN_CYCLES < 1) begin : g_bad_win
      $error("wdog_lockable: WIN_CYCLES must be at least 1");
   end
   if (XTAL_BASE < 1 || RC_BASE < 1) begin : g_bad_base
      $error("wdog_lockable: base counts must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("wdog_lockable: ADDR_W must be at least 1");
   end

   wdog_cfg_t cfg;
   logic      win_open;
   logic      fire;

   wdog_win #(.WIN_CYCLES(WIN_CYCLES)) u_win (
      .clk_i    (clk_i),
      .por_ni   (por_ni),
      .reopen_i (stop_wake_i || fire),
      .open_o   (win_open)
   );

   wdog_cfg #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_cfg (
      .clk_i      (clk_i),
      .por_ni     (por_ni),
      .win_open_i (win_open),
      .restore_i  (fire),
      .we_i       (cfg_we_i),
      .addr_i     (cfg_addr_i),
      .wdata_i    (cfg_wdata_i),
      .cfg_o      (cfg)
   );

   wdog_cnt #(.XTAL_BASE(XTAL_BASE), .RC_BASE(RC_BASE)) u_cnt (
      .clk_i     (clk_i),
      .por_ni    (por_ni),
      .cfg_i     (cfg),
      .rc_tick_i (rc_tick_i),
      .kick_i    (kick_i),
      .halt_i    (halt_i),
      .stop_i    (stop_i),
      .fire_o    (fire)
   );

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)   wdt_cause_o <= 1'b0;
      else if (fire) wdt_cause_o <= 1'b1;
   end

   assign wdt_rst_o = fire;

   p_cause_set_r12: assert property (@(posedge clk_i) disable iff (!por_ni)
      wdt_rst_o |=> wdt_cause_o);
   p_cause_sticky_r12: assert property (@(posedge clk_i) disable iff (!por_ni)
      wdt_cause_o |=> wdt_cause_o);

endmodule

// File: tb/wdog_lockable_bench.sv
`timescale 1ns/1ps
module wdog_lockable_bench;
   localparam int XB  = 256;
   localparam int RB  = 5;
   localparam int WIN = 128;

   logic       clk_i = 1'b0;
   logic       por_ni = 1'b0;
   logic       rc_tick_i = 1'b0, kick_i = 1'b0, halt_i = 1'b0, stop_i = 1'b0;
   logic       stop_wake_i = 1'b0, cfg_we_i = 1'b0;
   logic [7:0] cfg_addr_i = 8'h00, cfg_wdata_i = 8'h00;
   logic       wdt_rst_o, wdt_cause_o;

   int n_chk = 0, n_fail = 0, ph = 0;
   bit last_tick, done = 0;

   always #4 clk_i = ~clk_i;

   wdog_lockable #(.WIN_CYCLES(WIN), .ADDR_W(8), .CFG_ADDR(8'h0F),
                   .XTAL_BASE(XB), .RC_BASE(RB)) u_wdog_lockable (
      .clk_i(clk_i), .por_ni(por_ni), .rc_tick_i(rc_tick_i), .kick_i(kick_i),
      .halt_i(halt_i), .stop_i(stop_i), .stop_wake_i(stop_wake_i),
      .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
      .wdt_rst_o(wdt_rst_o), .wdt_cause_o(wdt_cause_o));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // one clock: RC tick is high one clock in three
   task automatic cyc();
      rc_tick_i = (ph == 0);
      ph = (ph + 1) % 3;
      last_tick = rc_tick_i;
      @(negedge clk_i);
   endtask

   task automatic do_por();
      por_ni = 1'b0;
      repeat (2) cyc();
      por_ni = 1'b1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
      cyc();
      cfg_we_i = 1'b0;
   endtask

   // counts edges and RC ticks until the pulse appears
   task automatic wait_rst(output int ncyc, output int nticks);
      ncyc = 0; nticks = 0;
      while (!wdt_rst_o && ncyc < 20000) begin
         cyc();
         ncyc++;
         if (last_tick) nticks++;
      end
   endtask

   task automatic kick_measure(output int ncyc, output int nticks);
      kick_i = 1'b1; cyc(); kick_i = 1'b0;
      wait_rst(ncyc, nticks);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk_i);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      int c, t;
      @(negedge clk_i);
      do_por();
      // R1: reset state and silence without kick
      chk(wdt_rst_o == 0, "R1 rst after por", wdt_rst_o, 0);
      chk(wdt_cause_o == 0, "R12 cause after por", wdt_cause_o, 0);
      c = 0;
      repeat (3000) begin cyc(); if (wdt_rst_o) c++; end
      chk(c == 0, "R1 no pulse without kick", c, 0);

      // R5 + R4: defaults give RC tap 01
      kick_measure(c, t);
      chk(t == 2 * RB, "R5 default timeout ticks", t, 2 * RB);
      cyc();
      chk(wdt_rst_o == 0, "R11 pulse one cycle", wdt_rst_o, 0);
      chk(wdt_cause_o == 1, "R12 cause set", wdt_cause_o, 1);

      // R3: clock source sweep
      for (int tp = 0; tp < 4; tp++) begin
         int exp;
         exp = XB << ((tp == 3) ? 4 : tp);
         do_por();
         wr(8'h0F, 8'h1C | 8'(tp));
         kick_measure(c, t);
         chk(c == exp, $sformatf("R3 xtal tap %0d", tp), c, exp);
      end
      // R4: RC sweep
      for (int tp = 0; tp < 4; tp++) begin
         int exp;
         exp = RB << ((tp == 3) ? 4 : tp);
         do_por();
         wr(8'h0F, 8'h0C | 8'(tp));
         kick_measure(c, t);
         chk(t == exp, $sformatf("R4 rc tap %0d", tp), t, exp);
      end

      // R2: mid-count kick restarts
      do_por();
      wr(8'h0F, 8'h1C);
      kick_i = 1; cyc(); kick_i = 0;
      repeat (100) cyc();
      kick_measure(c, t);
      chk(c == XB, "R2 restart", c, XB);

      // R13: kick on the terminal edge
      do_por();
      wr(8'h0F, 8'h1C);
      kick_i = 1; cyc(); kick_i = 0;
      repeat (XB - 1) cyc();
      kick_i = 1; cyc(); kick_i = 0;
      chk(wdt_rst_o == 0, "R13 kick beats terminal", wdt_rst_o, 0);
      wait_rst(c, t);
      chk(c == XB, "R13 count restarted", c, XB);

      // R11: defaults restored, window reopens after a pulse
      cyc();
      kick_measure(c, t);
      chk(t == 2 * RB, "R11 defaults restored", t, 2 * RB);
      cyc();
      wr(8'h0F, 8'h1D);
      kick_measure(c, t);
      chk(c == 2 * XB, "R11 window reopened", c, 2 * XB);

      // R12: stop wake does not clear cause, POR does
      cyc();
      stop_wake_i = 1; cyc(); stop_wake_i = 0;
      chk(wdt_cause_o == 1, "R12 sticky over wake", wdt_cause_o, 1);
      do_por();
      chk(wdt_cause_o == 0, "R12 cleared by por", wdt_cause_o, 0);

      // R8: window edges 127 and 128
      do_por();
      repeat (WIN - 1) cyc();
      wr(8'h0F, 8'h1C);
      kick_measure(c, t);
      chk(c == XB, "R8 write on last open edge", c, XB);
      do_por();
      repeat (WIN) cyc();
      wr(8'h0F, 8'h1C);
      kick_measure(c, t);
      chk(t == 2 * RB && c != XB, "R8 write on edge 128 ignored", t, 2 * RB);
      // R8: stop wake reopens
      do_por();
      repeat (200) cyc();
      stop_wake_i = 1; cyc(); stop_wake_i = 0;
      wr(8'h0F, 8'h1C);
      kick_measure(c, t);
      chk(c == XB, "R8 reopened by stop wake", c, XB);

      // R9: wrong address ignored
      do_por();
      wr(8'h0E, 8'h1C);
      kick_measure(c, t);
      chk(t == 2 * RB, "R9 other address ignored", t, 2 * RB);

      // R10: reserved bits dropped
      do_por();
      wr(8'h0F, 8'hFC);
      kick_measure(c, t);
      chk(c == XB, "R10 reserved bits", c, XB);

      // R6: halt freeze vs run
      do_por();
      wr(8'h0F, 8'h18);
      halt_i = 1;
      kick_i = 1; cyc(); kick_i = 0;
      c = 0;
      repeat (600) begin cyc(); if (wdt_rst_o) c++; end
      chk(c == 0, "R6 frozen in halt", c, 0);
      halt_i = 0;
      wait_rst(c, t);
      chk(c == XB, "R6 resumes after halt", c, XB);
      do_por();
      halt_i = 1;
      kick_measure(c, t);
      halt_i = 0;
      chk(c == 2 * RB * 3 || t == 2 * RB, "R6 runs in halt by default", t, 2 * RB);

      // R7: stop freeze vs run
      do_por();
      wr(8'h0F, 8'h14);
      stop_i = 1;
      kick_i = 1; cyc(); kick_i = 0;
      c = 0;
      repeat (600) begin cyc(); if (wdt_rst_o) c++; end
      chk(c == 0, "R7 frozen in stop", c, 0);
      stop_i = 0;
      wait_rst(c, t);
      chk(c == XB, "R7 resumes after stop", c, XB);
      do_por();
      wr(8'h0F, 8'h1C);
      stop_i = 1;
      kick_measure(c, t);
      stop_i = 0;
      chk(c == XB, "R7 runs in stop when set", c, XB);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule